// File: doc/BRIEF.md
# T1 Robbed-Bit Signalling Inserter

This block sits on the transmit path of a 24-channel T1 line. It takes the bit-serial DS1 frame stream from an upstream framer and writes per-channel ABCD signalling into the least significant bit of each channel octet in the signalling frames of the superframe. It works in the 12-frame (D4) superframe and in the 24-frame extended superframe. The framer supplies a framing-bit marker, a superframe alignment strobe, the timeslot (channel) index and the bit index within the octet. The block counts frames by itself and wraps the count at 12 or 24 according to the latched mode.

The signalling values come from one of two places. One is a bank of 24 four-bit registers, written and read through a small processor port that spans two address pages. The other is a serial control line that carries each channel's nibble during that channel's timeslot. A select input chooses the source. All configuration and all 24 signalling nibbles are captured at the superframe boundary, so every superframe carries one consistent set of values.

Top module: `rbs_inserter`

## Requirements
- R1: In the extended mode, with signalling enabled, the A bit (register bit 3) of channel n replaces bit position 8 (bit_idx 7, the last bit on the line) of channel n's octet in frame 6 of the superframe.
- R2: Under the same conditions, the B bit (register bit 2) replaces bit position 8 of channel n's octet in frame 12.
- R3: In the extended mode, the C bit (bit 1) goes into bit position 8 of frame 18 and the D bit (bit 0) into frame 24, and the frame count wraps after 24 frames.
- R4: In the 12-frame mode, the count wraps after 12 frames and only A (frame 6) and B (frame 12) are inserted. C and D never reach the line.
- R5: The output equals the input delayed by one clock in these cases: on the framing bit, on bit positions 1 to 7, in non-signalling frames, and in every frame of a superframe that began with signalling disabled.
- R6: Page 0 offsets 16 to 31 address channels 1 to 16, and page 1 offsets 16 to 23 address channels 17 to 24. A read returns the nibble in bits 3:0 with bits 7:4 zero. Any other offset reads zero, and a write to it changes nothing.
- R7: When src_reg_sel is high, the nibbles come from the registers. When it is low, they come from ctl_si, which carries A, B, C, D on bit_idx 4, 5, 6, 7 of the channel's timeslot. That nibble is held until the next superframe boundary uses it.
- R8: Mode, enable, source and all signalling nibbles are sampled at the superframe boundary. A register write or a mode change made mid-superframe first shows in the next superframe.
- R9: Before the first framing bit after reset, nothing is inserted. A framing bit with sf_align high makes that frame frame 1.
- R10: After reset, dout is 0 and every channel register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per cycle |
| rst_n | input | 1 | Active-low reset |
| sig_en | input | 1 | Signalling insertion enable (latched per superframe) |
| esf_mode | input | 1 | 1 = 24-frame superframe, 0 = 12-frame (latched per superframe) |
| src_reg_sel | input | 1 | 1 = register source, 0 = serial control source |
| f_bit | input | 1 | Current bit is the framing bit |
| sf_align | input | 1 | With f_bit, forces this frame to be frame 1 |
| ts_idx | input | TS_W | Channel index 0..23 of the current bit |
| bit_idx | input | 3 | Bit index within the octet, 0 = first, 7 = LSB |
| din | input | 1 | Incoming line bit |
| ctl_si | input | 1 | Serial per-timeslot signalling control |
| cpu_we | input | 1 | Register write strobe |
| cpu_page | input | 1 | Register page select |
| cpu_addr | input | ADDR_W | Register offset within the page |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data for page/offset |
| dout | output | 1 | Outgoing line bit, one cycle after din |

## Verification
The hardest situation to set up is a change that lands in the middle of a superframe: a register write, a mode switch or a new serial nibble. It must leave the current superframe untouched and appear in the next one, possibly with a different wrap length. The bench streams whole superframes and places a write and a mode switch inside particular frames. It also changes the serial nibble pattern halfway through a superframe. A bench-side frame and snapshot model then predicts every output bit, so an early effect or a late one shows up as a mismatch in a specific frame. A mid-count alignment strobe is driven as well, which shows that the count restarts at frame 1.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
   // octet geometry on the line: index 0 is sent first, index 7 is the LSB
   localparam int OCT_W   = 3;
   localparam int LSB_POS = 7;
   // one signalling letter per slot, A in the top bit
   localparam int NIB_W   = 4;

   typedef logic [NIB_W-1:0] abcd_t;
endpackage

// File: rtl/rbs_cpu_regs.sv
module rbs_cpu_regs import rbs_pkg::*; #(
   parameter int NUM_CH     = 24,
   parameter int ADDR_W     = 5,
   parameter int DATA_W     = 8,
   parameter int PAGE_BASE  = 16,
   parameter int PAGE_SLOTS = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         we,
   input  logic                         page,
   input  logic [ADDR_W-1:0]            addr,
   input  logic [DATA_W-1:0]            wdata,
   output logic [DATA_W-1:0]            rdata,
   output logic [NUM_CH-1:0][NIB_W-1:0] regs_o
);
   localparam int IDX_W = $clog2(2 * PAGE_SLOTS) + 1;

   generate
      if (PAGE_BASE + PAGE_SLOTS > (1 << ADDR_W)) begin : g_bad_window
         $error("register window does not fit the offset width");
      end
      if (NUM_CH > 2 * PAGE_SLOTS) begin : g_bad_pages
         $error("two pages cannot hold all channels");
      end
      if (DATA_W < NIB_W) begin : g_bad_data
         $error("data width narrower than a signalling nibble");
      end
   endgenerate

   logic             in_window;
   logic [IDX_W-1:0] ch_idx;
   logic             ch_ok;

   always_comb begin
      in_window = (int'(addr) >= PAGE_BASE) && (int'(addr) < PAGE_BASE + PAGE_SLOTS);
      ch_idx    = IDX_W'(int'(page) * PAGE_SLOTS + int'(addr) - PAGE_BASE);
      ch_ok     = in_window && (int'(ch_idx) < NUM_CH);
   end

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               regs_o[g] <= '0;
            else if (we && ch_ok && ch_idx == IDX_W'(g))
               regs_o[g] <= wdata[NIB_W-1:0];
         end
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (ch_ok && ch_idx == IDX_W'(i))
            rdata[NIB_W-1:0] = regs_o[i];
      end
   end

   logic unused_wdata_hi;
   assign unused_wdata_hi = ^wdata[DATA_W-1:NIB_W];
endmodule

// File: rtl/rbs_serial_capture.sv
module rbs_serial_capture import rbs_pkg::*; #(
   parameter int NUM_CH = 24,
   parameter int TS_W   = 5
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         f_bit,
   input  logic [TS_W-1:0]              ts_idx,
   input  logic [OCT_W-1:0]             bit_idx,
   input  logic                         ctl_si,
   output logic [NUM_CH-1:0][NIB_W-1:0] shadow_o
);
   localparam int FIRST_POS = LSB_POS - NIB_W + 1;

   generate
      if (NIB_W < 2 || FIRST_POS < 0) begin : g_bad_nib
         $error("nibble must span 2..8 octet bits");
      end
   endgenerate

   logic [NIB_W-2:0] acc_q;
   logic             in_field;
   logic             last_bit;

   assign in_field = !f_bit && (int'(bit_idx) >= FIRST_POS);
   assign last_bit = !f_bit && (bit_idx == OCT_W'(LSB_POS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc_q <= '0;
      else if (in_field && !last_bit)
         acc_q <= {acc_q[NIB_W-3:0], ctl_si};
   end

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_shadow
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               shadow_o[g] <= '0;
            else if (last_bit && ts_idx == TS_W'(g))
               shadow_o[g] <= {acc_q, ctl_si};
         end
      end
   endgenerate
endmodule

// File: rtl/rbs_frame_track.sv
module rbs_frame_track #(
   parameter int SF_LONG = 24,
   parameter int CNT_W   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             f_bit,
   input  logic             sf_align,
   input  logic             esf_mode,
   input  logic             sig_en,
   output logic [CNT_W-1:0] frm_cnt,
   output logic             started,
   output logic             mode_q,
   output logic             en_q,
   output logic             sf_load
);
   localparam int SF_SHORT = SF_LONG / 2;

   generate
      if (SF_LONG % 4 != 0 || SF_LONG < 4) begin : g_bad_len
         $error("superframe length must be a positive multiple of four");
      end
      if ((1 << CNT_W) <= SF_LONG) begin : g_bad_cnt
         $error("frame counter too narrow");
      end
   endgenerate

   logic at_last;

   always_comb begin
      if (mode_q)
         at_last = (frm_cnt == CNT_W'(SF_LONG - 1));
      else
         at_last = (frm_cnt == CNT_W'(SF_SHORT - 1));
   end

   assign sf_load = f_bit && (!started || sf_align || at_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frm_cnt <= '0;
         started <= 1'b0;
         mode_q  <= 1'b0;
         en_q    <= 1'b0;
      end else if (sf_load) begin
         frm_cnt <= '0;
         started <= 1'b1;
         mode_q  <= esf_mode;
         en_q    <= sig_en;
      end else if (f_bit) begin
         frm_cnt <= frm_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/rbs_inserter.sv
module rbs_inserter import rbs_pkg::*; #(
   parameter int NUM_CH     = 24,
   parameter int SF_LONG    = 24,
   parameter int TS_W       = 5,
   parameter int ADDR_W     = 5,
   parameter int DATA_W     = 8,
   parameter int PAGE_BASE  = 16,
   parameter int PAGE_SLOTS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sig_en,
   input  logic              esf_mode,
   input  logic              src_reg_sel,
   input  logic              f_bit,
   input  logic              sf_align,
   input  logic [TS_W-1:0]   ts_idx,
   input  logic [2:0]        bit_idx,
   input  logic              din,
   input  logic              ctl_si,
   input  logic              cpu_we,
   input  logic              cpu_page,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              dout
);
   localparam int CNT_W  = $clog2(SF_LONG + 1);
   localparam int N_SLOT = NIB_W;
   localparam int SPACE  = SF_LONG / N_SLOT;

   generate
      if ((1 << TS_W) < NUM_CH) begin : g_bad_ts
         $error("timeslot index too narrow for the channel count");
      end
   endgenerate

   logic [NUM_CH-1:0][NIB_W-1:0] regs;
   logic [NUM_CH-1:0][NIB_W-1:0] shadow;
   logic [NUM_CH-1:0][NIB_W-1:0] snap_q;
   logic [CNT_W-1:0]             frm_cnt;
   logic                         started;
   logic                         mode_q;
   logic                         en_q;
   logic                         sf_load;
   logic [N_SLOT-1:0]            slot_hit;
   abcd_t                        cur_nib;
   logic                         slot_any;
   logic                         slot_bit;
   logic                         ts_ok;
   logic                         ins_now;
   logic                         dout_q;

   rbs_cpu_regs #(
      .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .PAGE_BASE(PAGE_BASE), .PAGE_SLOTS(PAGE_SLOTS)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .we(cpu_we), .page(cpu_page),
      .addr(cpu_addr), .wdata(cpu_wdata), .rdata(cpu_rdata), .regs_o(regs)
   );

   rbs_serial_capture #(.NUM_CH(NUM_CH), .TS_W(TS_W)) i_ser (
      .clk(clk), .rst_n(rst_n), .f_bit(f_bit), .ts_idx(ts_idx),
      .bit_idx(bit_idx), .ctl_si(ctl_si), .shadow_o(shadow)
   );

   rbs_frame_track #(.SF_LONG(SF_LONG), .CNT_W(CNT_W)) i_track (
      .clk(clk), .rst_n(rst_n), .f_bit(f_bit), .sf_align(sf_align),
      .esf_mode(esf_mode), .sig_en(sig_en), .frm_cnt(frm_cnt),
      .started(started), .mode_q(mode_q), .en_q(en_q), .sf_load(sf_load)
   );

   // superframe snapshot of the selected source
   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_snap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               snap_q[g] <= '0;
            else if (sf_load)
               snap_q[g] <= src_reg_sel ? regs[g] : shadow[g];
         end
      end
      // slot k sits in the last frame of the k-th quarter of the long superframe
      for (genvar k = 0; k < N_SLOT; k++) begin : g_slot
         assign slot_hit[k] = (frm_cnt == CNT_W'((k + 1) * SPACE - 1));
      end
   endgenerate

   always_comb begin
      cur_nib = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (ts_idx == TS_W'(i))
            cur_nib = snap_q[i];
      end
   end

   always_comb begin
      slot_any = 1'b0;
      slot_bit = 1'b0;
      for (int k = 0; k < N_SLOT; k++) begin
         if (slot_hit[k]) begin
            slot_any = 1'b1;
            slot_bit = cur_nib[N_SLOT-1-k];
         end
      end
   end

   assign ts_ok   = int'(ts_idx) < NUM_CH;
   assign ins_now = started && en_q && !f_bit && ts_ok && slot_any &&
                    (bit_idx == 3'(LSB_POS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dout_q <= 1'b0;
      else
         dout_q <= ins_now ? slot_bit : din;
   end

   assign dout = dout_q;
endmodule

// File: rtl/rbs_inserter_chk.sv
module rbs_inserter_chk #(
   parameter int NUM_CH    = 24,
   parameter int SF_LONG   = 24,
   parameter int CNT_W     = 5,
   parameter int ADDR_W    = 5,
   parameter int DATA_W    = 8,
   parameter int PAGE_BASE = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                f_bit,
   input logic [2:0]          bit_idx,
   input logic                din,
   input logic                dout,
   input logic                started,
   input logic                mode_q,
   input logic [CNT_W-1:0]    frm_cnt,
   input logic                sf_load,
   input logic [NUM_CH*4-1:0] snap_q,
   input logic [ADDR_W-1:0]   cpu_addr,
   input logic [DATA_W-1:0]   cpu_rdata
);
   // R5
   fbit_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      f_bit |=> dout == $past(din));

   // R5
   upper_bits_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_idx != 3'd7) |=> dout == $past(din));

   // R9
   pre_sync_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !started |=> dout == $past(din));

   // R4
   short_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q |-> frm_cnt < CNT_W'(SF_LONG / 2));

   // R3
   long_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frm_cnt < CNT_W'(SF_LONG));

   // R8
   snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sf_load |=> $stable(snap_q));

   // R8
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !f_bit |=> $stable(mode_q));

   // R6
   low_offset_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cpu_addr) < PAGE_BASE) |-> cpu_rdata == '0);
endmodule

bind rbs_inserter rbs_inserter_chk #(
   .NUM_CH(NUM_CH), .SF_LONG(SF_LONG), .CNT_W(CNT_W),
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BASE(PAGE_BASE)
) i_rbs_chk (
   .clk(clk), .rst_n(rst_n), .f_bit(f_bit), .bit_idx(bit_idx),
   .din(din), .dout(dout), .started(started), .mode_q(mode_q),
   .frm_cnt(frm_cnt), .sf_load(sf_load), .snap_q(snap_q),
   .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata)
);

// File: tb/test_rbs_inserter.sv
module test_rbs_inserter;
   localparam int CLK_PERIOD = 10;
   localparam int NCH        = 24;

   logic       clk = 0;
   logic       rst_n = 0;
   logic       sig_en = 0, esf_mode = 0, src_reg_sel = 0;
   logic       f_bit = 0, sf_align = 0, din = 0, ctl_si = 0;
   logic [4:0] ts_idx = '0;
   logic [2:0] bit_idx = '0;
   logic       cpu_we = 0, cpu_page = 0;
   logic [4:0] cpu_addr = '0;
   logic [7:0] cpu_wdata = '0;
   logic [7:0] cpu_rdata;
   logic       dout;

   rbs_inserter i_rbs_inserter (
      .clk(clk), .rst_n(rst_n), .sig_en(sig_en), .esf_mode(esf_mode),
      .src_reg_sel(src_reg_sel), .f_bit(f_bit), .sf_align(sf_align),
      .ts_idx(ts_idx), .bit_idx(bit_idx), .din(din), .ctl_si(ctl_si),
      .cpu_we(cpu_we), .cpu_page(cpu_page), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .dout(dout)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int errors = 0;
   int checks = 0;

   // bench-side configuration, applied at each beat
   bit    cfg_en = 1, cfg_long = 0, cfg_src = 1;
   int    ser_salt = 0;
   string cur_tag = "";
   int    beat_no = 0;

   // reference model of the requirements
   logic [3:0] m_regs [NCH];
   logic [3:0] m_shadow [NCH];
   logic [3:0] m_snap [NCH];
   bit         m_started = 0, m_long = 0, m_en = 0, m_src = 0;
   int         m_cnt = 0;
   bit         exp_valid = 0;
   logic       exp_bit = 0;
   string      exp_req = "";

   function automatic logic [3:0] reg_nib(int ch, int salt);
      return 4'((ch * 5 + salt * 9 + 2) & 15);
   endfunction

   function automatic logic [3:0] ser_nib(int ch, int salt);
      return 4'((ch * 7 + salt * 3 + 1) & 15);
   endfunction

   function automatic logic pat(int n, int ts, int b);
      int v;
      v = (n * 29) ^ (ts * 7) ^ (b * 13);
      return v[3] ^ v[0];
   endfunction

   task automatic chk(string req, int act, int exp, string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic beat(input bit f, input bit al, input int ts, input int bi,
                       input bit we, input bit pg, input int ad, input int wd);
      logic       d, c, e;
      logic [3:0] n;
      int         slot, ch;
      string      req;
      @(negedge clk);
      if (exp_valid) chk(exp_req, int'(dout), int'(exp_bit), "dout");
      d = pat(beat_no, ts, bi);
      beat_no++;
      n = ser_nib(ts, ser_salt);
      c = (!f && bi >= 4) ? n[7 - bi] : 1'b0;
      f_bit = f; sf_align = al; ts_idx = 5'(ts); bit_idx = 3'(bi);
      din = d; ctl_si = c; cpu_we = we; cpu_page = pg;
      cpu_addr = 5'(ad); cpu_wdata = 8'(wd);
      sig_en = cfg_en; esf_mode = cfg_long; src_reg_sel = cfg_src;
      // expected output for this beat
      e = d;
      req = m_started ? "R5" : "R9";
      if (!f && m_started && m_en && bi == 7 && ts < NCH) begin
         slot = -1;
         if (m_cnt == 5) slot = 0;
         else if (m_cnt == 11) slot = 1;
         else if (m_cnt == 17) slot = 2;
         else if (m_cnt == 23) slot = 3;
         if (slot >= 0) begin
            e = m_snap[ts][3 - slot];
            if (cur_tag != "") req = cur_tag;
            else if (!m_src) req = "R7";
            else if (slot == 0) req = "R1";
            else if (slot == 1) req = "R2";
            else req = "R3";
         end
      end
      exp_bit = e; exp_req = req; exp_valid = 1;
      // state after this edge
      if (f) begin
         if (!m_started || al || m_cnt == (m_long ? 23 : 11)) begin
            m_cnt = 0; m_started = 1; m_long = cfg_long; m_en = cfg_en;
            m_src = cfg_src;
            for (int i = 0; i < NCH; i++) m_snap[i] = cfg_src ? m_regs[i] : m_shadow[i];
         end else begin
            m_cnt++;
         end
      end else if (bi == 7 && ts < NCH) begin
         m_shadow[ts] = n;
      end
      if (we) begin
         ch = int'(pg) * 16 + ad - 16;
         if (ad >= 16 && ad < 32 && ch < NCH) m_regs[ch] = 4'(wd);
      end
   endtask

   task automatic frame(input bit al, input int wr_ch, input int wr_val);
      beat(1, al, 0, 0, 0, 0, 0, 0);
      for (int ts = 0; ts < NCH; ts++) begin
         for (int b = 0; b < 8; b++) begin
            if (wr_ch >= 0 && ts == 2 && b == 0)
               beat(0, 0, ts, b, 1, wr_ch >= 16, 16 + wr_ch % 16, wr_val);
            else
               beat(0, 0, ts, b, 0, 0, 0, 0);
         end
      end
   endtask

   task automatic cpu_wr(input bit pg, input int ad, input int wd);
      beat(0, 0, 0, 0, 1, pg, ad, wd);
   endtask

   task automatic rd_chk(input bit pg, input int ad, input int exp, input string req);
      beat(0, 0, 0, 0, 0, pg, ad, 0);
      #1;
      chk(req, int'(cpu_rdata), exp, "cpu_rdata");
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      checks++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < NCH; i++) begin
         m_regs[i] = '0; m_shadow[i] = '0; m_snap[i] = '0;
      end
      repeat (4) @(negedge clk);
      chk("R10", int'(dout), 0, "dout in reset");
      rst_n = 1;
      chk("R10", int'(dout), 0, "dout after reset");
      for (int ch = 0; ch < NCH; ch++) rd_chk(ch >= 16, 16 + ch % 16, 0, "R10");

      // register map and readback
      for (int ch = 0; ch < NCH; ch++) cpu_wr(ch >= 16, 16 + ch % 16, 8'hA0 | reg_nib(ch, 0));
      for (int ch = 0; ch < NCH; ch++) rd_chk(ch >= 16, 16 + ch % 16, reg_nib(ch, 0), "R6");
      cpu_wr(0, 4, 8'hFF);
      cpu_wr(1, 24, 8'hFF);
      cpu_wr(1, 31, 8'hFF);
      rd_chk(0, 4, 0, "R6");
      rd_chk(1, 24, 0, "R6");
      rd_chk(1, 31, 0, "R6");
      for (int ch = 0; ch < NCH; ch++) rd_chk(ch >= 16, 16 + ch % 16, reg_nib(ch, 0), "R6");

      // LSB beats before any framing bit
      for (int ts = 0; ts < NCH; ts++) beat(0, 0, ts, 7, 0, 0, 0, 0);

      // 12-frame mode, register source
      cfg_en = 1; cfg_long = 0; cfg_src = 1; cur_tag = "R4";
      for (int i = 0; i < 12; i++) frame(i == 0, -1, 0);

      // mid-superframe write and mode switch
      cur_tag = "R8";
      for (int i = 0; i < 24; i++) begin
         frame(0, (i == 2) ? 5 : ((i == 14) ? 20 : -1), (i == 2) ? 9 : 6);
         if (i == 15) cfg_long = 1;
      end
      for (int i = 0; i < 24; i++) frame(0, -1, 0);

      // extended mode, register source
      cur_tag = "";
      for (int i = 0; i < 24; i++) frame(0, -1, 0);

      // serial source, pattern changed mid-superframe
      cfg_src = 0; ser_salt = 1;
      for (int i = 0; i < 24; i++) frame(0, -1, 0);
      ser_salt = 2;
      for (int i = 0; i < 12; i++) frame(0, -1, 0);
      ser_salt = 3;
      for (int i = 0; i < 36; i++) frame(0, -1, 0);

      // disabled
      cfg_en = 0; cur_tag = "R5";
      for (int i = 0; i < 48; i++) frame(0, -1, 0);
      cfg_en = 1;

      // realignment mid-count
      cfg_src = 1; cur_tag = "R9";
      for (int i = 0; i < 10; i++) frame(0, -1, 0);
      frame(1, -1, 0);
      for (int i = 0; i < 23; i++) frame(0, -1, 0);

      // back to 12-frame mode with serial source
      cfg_long = 0; cfg_src = 0; cur_tag = "R4";
      for (int i = 0; i < 36; i++) frame(0, -1, 0);

      beat(0, 0, 0, 0, 0, 0, 0, 0);
      beat(0, 0, 0, 0, 0, 0, 0, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule